// File: doc/BRIEF.md
# Eight-Pin I/O Port with Per-Pin Peripheral Overrides

This block controls a bank of general-purpose pins, eight by default. Software sets each pin's direction through a direction register. A second register holds a bit per pin that is the driven level when the pin is an output, and the pull-up request when the pin is an input. A synchronized copy of the pad levels can be read back on the same small register bus. A configuration register holds a single pull-up kill bit that turns off every register-requested pull-up at once.

Each pin can be taken over by an on-chip peripheral for four separate attributes: the pull-up, the output-driver enable, the driven value and the digital-input enable. Each attribute has its own enable/value pair, and the attributes are independent of one another. When no override is active, the digital-input enable follows the sleep state. A gated but unsynchronized copy of every pad input goes straight to the peripherals, and each peripheral synchronizes that copy itself.

The register bus writes one whole register per cycle through a write strobe. Reads are combinational from the addressed register.

Top module: `pad_port_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it falls, the direction, output and configuration registers read 0. All pad outputs then show inputs with no pull-up and no drive.
- R2: For a pin with no pull-up override, `pad_pu_o` is 1 only when its direction bit is 0, its output-register bit is 1 and the kill bit is 0.
- R3: The kill bit is bit 2 of the configuration register at address 3. The other bits of that register read 0 and ignore writes.
- R4: For a pin whose `pu_ovr_en_i` bit is 1, `pad_pu_o` equals `pu_ovr_val_i`, whatever the direction bit, output-register bit and kill bit are.
- R5: `pad_oe_o` equals `dir_ovr_val_i` for a pin whose `dir_ovr_en_i` bit is 1. Otherwise it equals that pin's direction bit.
- R6: `pad_out_o` equals `val_ovr_val_i` for a pin whose output driver is on and whose `val_ovr_en_i` bit is 1. Otherwise it equals the output-register bit.
- R7: `pad_ie_o` equals `ie_ovr_val_i` for a pin whose `ie_ovr_en_i` bit is 1. Otherwise it is 1 while `sleep_i` is 0 and equals `sleep_keep_i` while `sleep_i` is 1.
- R8: A write with `bus_wr_i` high stores `bus_wdata_i` at the clock edge. Address 0 is the direction register and address 1 is the output register. `bus_rdata_o` shows the addressed register in the same cycle.
- R9: Address 2 reads the pin levels through a two-flop synchronizer, two clocks after the gated level is presented. Writes to address 2 have no effect.
- R10: `periph_din_o` is the pad input ANDed with `pad_ie_o`, with no register in the path. The synchronizer input is this same gated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 2 | Register address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data of the addressed register |
| pu_ovr_en_i | input | 8 | Pull-up override enable per pin |
| pu_ovr_val_i | input | 8 | Pull-up override value per pin |
| dir_ovr_en_i | input | 8 | Output-enable override enable per pin |
| dir_ovr_val_i | input | 8 | Output-enable override value per pin |
| val_ovr_en_i | input | 8 | Driven-value override enable per pin |
| val_ovr_val_i | input | 8 | Driven-value override value per pin |
| ie_ovr_en_i | input | 8 | Input-enable override enable per pin |
| ie_ovr_val_i | input | 8 | Input-enable override value per pin |
| sleep_i | input | 1 | Chip is in a sleep state |
| sleep_keep_i | input | 8 | Pins whose input stays enabled during sleep |
| pad_in_i | input | 8 | Raw pad levels |
| pad_oe_o | output | 8 | Output-driver enable per pin |
| pad_out_o | output | 8 | Driven value per pin |
| pad_pu_o | output | 8 | Pull-up enable per pin |
| pad_ie_o | output | 8 | Digital-input enable per pin |
| periph_din_o | output | 8 | Gated, unsynchronized pad input for peripherals |

## Verification
The assertions assume that `bus_addr_i`, `bus_wdata_i` and the strobe are stable at each rising edge. The synchronizer-latency property also assumes that the gated pad value is sampled only at clock edges, so that a metastable capture is never modelled. The bench changes every input, including the pad levels, only on the falling edge, which keeps all sampled values clean. The stimulus weights the override enables so that each pin mixes overridden and register-controlled attributes in the same cycle. It also toggles sleep, so that both input-enable sources are exercised.

// File: rtl/pad_port_pkg.sv
package pad_port_pkg;
    localparam int unsigned REG_AW = 2;

    typedef enum logic [REG_AW-1:0] {
        RA_DIR = 2'd0,
        RA_OUT = 2'd1,
        RA_PIN = 2'd2,
        RA_CFG = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/port_regs.sv
module port_regs
    import pad_port_pkg::*;
#(
    parameter int unsigned W       = 8,
    parameter int unsigned KILL_POS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_i,
    input  logic [REG_AW-1:0] addr_i,
    input  logic [W-1:0]      wdata_i,
    input  logic [W-1:0]      pin_i,
    output logic [W-1:0]      dir_o,
    output logic [W-1:0]      outr_o,
    output logic              kill_o,
    output logic [W-1:0]      rdata_o
);
    typedef struct packed {
        logic [W-1:0] dir;
        logic [W-1:0] outr;
        logic         kill;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_i) begin
            unique case (reg_addr_e'(addr_i))
                RA_DIR:  regs_d.dir  = wdata_i;
                RA_OUT:  regs_d.outr = wdata_i;
                RA_CFG:  regs_d.kill = wdata_i[KILL_POS];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) regs_q <= '0;
        else     regs_q <= regs_d;
    end

    always_comb begin
        unique case (reg_addr_e'(addr_i))
            RA_DIR:  rdata_o = regs_q.dir;
            RA_OUT:  rdata_o = regs_q.outr;
            RA_PIN:  rdata_o = pin_i;
            default: rdata_o = W'(regs_q.kill) << KILL_POS;
        endcase
    end

    assign dir_o  = regs_q.dir;
    assign outr_o = regs_q.outr;
    assign kill_o = regs_q.kill;

    AST_DIR_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wr_i && addr_i == RA_DIR) |=> (dir_o == $past(wdata_i)))
        else $error("direction write lost"); // R8
endmodule

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int unsigned W      = 8,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] dout_o
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = din_i;
        for (int i = 1; i < STAGES; i++) stg_d[i] = stg_q[i-1];
    end

    always_ff @(posedge clk) begin
        if (rst) stg_q <= '0;
        else     stg_q <= stg_d;
    end

    assign dout_o = stg_q[STAGES-1];
endmodule

// File: rtl/pad_mux.sv
module pad_mux #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir_i,
    input  logic [W-1:0] outr_i,
    input  logic         kill_i,
    input  logic [W-1:0] pu_en_i,
    input  logic [W-1:0] pu_val_i,
    input  logic [W-1:0] dir_en_i,
    input  logic [W-1:0] dir_val_i,
    input  logic [W-1:0] val_en_i,
    input  logic [W-1:0] val_val_i,
    input  logic [W-1:0] ie_en_i,
    input  logic [W-1:0] ie_val_i,
    input  logic         sleep_i,
    input  logic [W-1:0] keep_i,
    input  logic [W-1:0] pad_i,
    output logic [W-1:0] oe_o,
    output logic [W-1:0] out_o,
    output logic [W-1:0] pu_o,
    output logic [W-1:0] ie_o,
    output logic [W-1:0] gated_o
);
    for (genvar p = 0; p < W; p++) begin : g_pin
        logic oe_p, ie_p, pu_reg_p, ie_state_p;

        always_comb begin
            oe_p       = dir_en_i[p] ? dir_val_i[p] : dir_i[p];
            pu_reg_p   = ~dir_i[p] & outr_i[p] & ~kill_i;
            ie_state_p = sleep_i ? keep_i[p] : 1'b1;
            ie_p       = ie_en_i[p] ? ie_val_i[p] : ie_state_p;
        end

        assign oe_o[p]    = oe_p;
        assign out_o[p]   = (oe_p & val_en_i[p]) ? val_val_i[p] : outr_i[p];
        assign pu_o[p]    = pu_en_i[p] ? pu_val_i[p] : pu_reg_p;
        assign ie_o[p]    = ie_p;
        assign gated_o[p] = pad_i[p] & ie_p;
    end
endmodule

// File: rtl/pad_port_ctrl.sv
module pad_port_ctrl
    import pad_port_pkg::*;
#(
    parameter int unsigned W        = 8,
    parameter int unsigned KILL_POS = 2,
    parameter int unsigned SYNC_N   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr_i,
    input  logic [REG_AW-1:0] bus_addr_i,
    input  logic [W-1:0]      bus_wdata_i,
    output logic [W-1:0]      bus_rdata_o,
    input  logic [W-1:0]      pu_ovr_en_i,
    input  logic [W-1:0]      pu_ovr_val_i,
    input  logic [W-1:0]      dir_ovr_en_i,
    input  logic [W-1:0]      dir_ovr_val_i,
    input  logic [W-1:0]      val_ovr_en_i,
    input  logic [W-1:0]      val_ovr_val_i,
    input  logic [W-1:0]      ie_ovr_en_i,
    input  logic [W-1:0]      ie_ovr_val_i,
    input  logic              sleep_i,
    input  logic [W-1:0]      sleep_keep_i,
    input  logic [W-1:0]      pad_in_i,
    output logic [W-1:0]      pad_oe_o,
    output logic [W-1:0]      pad_out_o,
    output logic [W-1:0]      pad_pu_o,
    output logic [W-1:0]      pad_ie_o,
    output logic [W-1:0]      periph_din_o
);
    logic [W-1:0] dir_q, outr_q, pin_q, gated;
    logic         kill_q;

    port_regs #(.W(W), .KILL_POS(KILL_POS)) u_regs (
        .clk(clk), .rst(rst), .wr_i(bus_wr_i), .addr_i(bus_addr_i),
        .wdata_i(bus_wdata_i), .pin_i(pin_q), .dir_o(dir_q),
        .outr_o(outr_q), .kill_o(kill_q), .rdata_o(bus_rdata_o)
    );

    pad_mux #(.W(W)) u_mux (
        .dir_i(dir_q), .outr_i(outr_q), .kill_i(kill_q),
        .pu_en_i(pu_ovr_en_i), .pu_val_i(pu_ovr_val_i),
        .dir_en_i(dir_ovr_en_i), .dir_val_i(dir_ovr_val_i),
        .val_en_i(val_ovr_en_i), .val_val_i(val_ovr_val_i),
        .ie_en_i(ie_ovr_en_i), .ie_val_i(ie_ovr_val_i),
        .sleep_i(sleep_i), .keep_i(sleep_keep_i), .pad_i(pad_in_i),
        .oe_o(pad_oe_o), .out_o(pad_out_o), .pu_o(pad_pu_o),
        .ie_o(pad_ie_o), .gated_o(gated)
    );

    pin_sync #(.W(W), .STAGES(SYNC_N)) u_sync (
        .clk(clk), .rst(rst), .din_i(gated), .dout_o(pin_q)
    );

    assign periph_din_o = gated;

    // cycles since reset, saturating, for the latency property
    logic [1:0] age_d, age_q;
    always_comb age_d = (age_q == 2'd2) ? age_q : age_q + 2'd1;
    always_ff @(posedge clk) begin
        if (rst) age_q <= '0;
        else     age_q <= age_d;
    end

    AST_KILL_PULLUPS: assert property (@(posedge clk) disable iff (rst)
        kill_q |-> ((pad_pu_o & ~pu_ovr_en_i) == '0))
        else $error("pull-up on while killed"); // R2
    AST_PU_OVR: assert property (@(posedge clk) disable iff (rst)
        ((pad_pu_o ^ pu_ovr_val_i) & pu_ovr_en_i) == '0)
        else $error("pull-up override ignored"); // R4
    AST_OE_SOURCE: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe_o ^ dir_q) & ~dir_ovr_en_i) == '0)
        else $error("driver enable not from direction"); // R5
    AST_DIN_GATED: assert property (@(posedge clk) disable iff (rst)
        (periph_din_o & ~pad_ie_o) == '0)
        else $error("disabled input leaks"); // R10
    AST_SYNC_LAT: assert property (@(posedge clk) disable iff (rst)
        (age_q == 2'd2 && SYNC_N == 2) |-> (pin_q == $past(periph_din_o, 2)))
        else $error("synchronizer latency"); // R9
endmodule

// File: tb/test_pad_port_ctrl.sv
module test_pad_port_ctrl;
    localparam int W = 8;
    localparam time HALF = 2.5ns;

    logic clk = 0, rst = 1;
    logic bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [W-1:0] wdata = 0, rdata;
    logic [W-1:0] pu_en = 0, pu_val = 0, dr_en = 0, dr_val = 0;
    logic [W-1:0] vo_en = 0, vo_val = 0, ie_en = 0, ie_val = 0;
    logic sleep = 0;
    logic [W-1:0] keep = 0, pad = 0;
    logic [W-1:0] oe, dout, pu, ie, pdin;

    int n_chk = 0, n_err = 0;
    bit done = 0;

    // reference state
    logic [W-1:0] m_dir = 0, m_out = 0, m_s1 = 0, m_s2 = 0;
    logic m_kill = 0;

    always #HALF clk = ~clk;

    pad_port_ctrl i_pad_port_ctrl (
        .clk(clk), .rst(rst), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .pu_ovr_en_i(pu_en), .pu_ovr_val_i(pu_val),
        .dir_ovr_en_i(dr_en), .dir_ovr_val_i(dr_val),
        .val_ovr_en_i(vo_en), .val_ovr_val_i(vo_val),
        .ie_ovr_en_i(ie_en), .ie_ovr_val_i(ie_val),
        .sleep_i(sleep), .sleep_keep_i(keep), .pad_in_i(pad),
        .pad_oe_o(oe), .pad_out_o(dout), .pad_pu_o(pu),
        .pad_ie_o(ie), .periph_din_o(pdin)
    );

    task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [W-1:0] exp_ie();
        logic [W-1:0] r;
        for (int p = 0; p < W; p++)
            r[p] = ie_en[p] ? ie_val[p] : (sleep ? keep[p] : 1'b1);
        return r;
    endfunction

    // compare every output against the reference, then advance one clock
    task automatic step();
        logic [W-1:0] e_oe, e_out, e_pu, e_ie, e_rd;
        #1;
        e_ie = exp_ie();
        for (int p = 0; p < W; p++) begin
            e_oe[p]  = dr_en[p] ? dr_val[p] : m_dir[p];
            e_out[p] = (e_oe[p] && vo_en[p]) ? vo_val[p] : m_out[p];
            e_pu[p]  = pu_en[p] ? pu_val[p]
                                : (!m_dir[p] && m_out[p] && !m_kill);
        end
        chk("R5 pad_oe", oe, e_oe);
        chk("R6 pad_out", dout, e_out);
        chk("R2/R4 pad_pu", pu, e_pu);
        chk("R7 pad_ie", ie, e_ie);
        chk("R10 periph_din", pdin, pad & e_ie);
        case (bus_addr)
            2'd0: begin e_rd = m_dir; chk(rst ? "R1 dir read" : "R8 dir read", rdata, e_rd); end
            2'd1: begin e_rd = m_out; chk(rst ? "R1 out read" : "R8 out read", rdata, e_rd); end
            2'd2: begin e_rd = m_s2;  chk("R9 pin read", rdata, e_rd); end
            default: begin e_rd = {5'b0, m_kill, 2'b0}; chk(rst ? "R1 cfg read" : "R3 cfg read", rdata, e_rd); end
        endcase
        @(posedge clk);
        if (rst) begin
            m_dir = 0; m_out = 0; m_kill = 0; m_s1 = 0; m_s2 = 0;
        end else begin
            if (bus_wr) begin
                if (bus_addr == 2'd0) m_dir = wdata;
                if (bus_addr == 2'd1) m_out = wdata;
                if (bus_addr == 2'd3) m_kill = wdata[2];
            end
            m_s2 = m_s1;
            m_s1 = pad & e_ie;
        end
        @(negedge clk);
    endtask

    task automatic bus(bit wr, logic [1:0] a, logic [W-1:0] d);
        bus_wr = wr; bus_addr = a; wdata = d;
        step();
    endtask

    initial begin
        #(HALF * 2 * 200000);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state, including a write attempt held off by reset
        for (int a = 0; a < 4; a++) bus(1, 2'(a), 8'hFF);
        rst = 0;
        for (int a = 0; a < 4; a++) bus(0, 2'(a), 8'h00);
        // R3: only bit 2 of the configuration register holds
        bus(1, 2'd3, 8'hFF);
        bus(0, 2'd3, 8'h00);
        bus(1, 2'd3, 8'hFB);
        bus(0, 2'd3, 8'h00);
        // R2: pull-ups from register, then killed
        bus(1, 2'd0, 8'h0F);
        bus(1, 2'd1, 8'hFF);
        bus(1, 2'd3, 8'h04);
        bus(1, 2'd3, 8'h00);
        // R9: writes to pin address ignored; pad latency
        pad = 8'hA5;
        bus(1, 2'd2, 8'h3C);
        bus(0, 2'd2, 8'h00);
        pad = 8'h5A;
        bus(0, 2'd2, 8'h00);
        bus(0, 2'd2, 8'h00);
        bus(0, 2'd2, 8'h00);
        // R7: sleep with keep mask, input override
        sleep = 1; keep = 8'h0F; bus(0, 2'd2, 8'h00);
        ie_en = 8'hF0; ie_val = 8'h30; bus(0, 2'd2, 8'h00);
        bus(0, 2'd2, 8'h00); bus(0, 2'd2, 8'h00);
        sleep = 0; ie_en = 0;
        // R4 R5 R6: all overrides against register values
        pu_en = 8'hFF; pu_val = 8'h81;
        dr_en = 8'hF0; dr_val = 8'hCC;
        vo_en = 8'hFF; vo_val = 8'h00;
        bus(0, 2'd0, 8'h00);
        pu_en = 0; dr_en = 0; vo_en = 0;
        // random mix
        for (int i = 0; i < 3000; i++) begin
            pu_en  = $urandom & $urandom; pu_val = $urandom;
            dr_en  = $urandom & $urandom; dr_val = $urandom;
            vo_en  = $urandom & $urandom; vo_val = $urandom;
            ie_en  = $urandom & $urandom; ie_val = $urandom;
            sleep  = ($urandom % 4) == 0; keep = $urandom;
            pad    = $urandom;
            rst    = ($urandom % 200) == 0;
            bus(($urandom % 3) == 0, 2'($urandom), 8'($urandom));
        end
        rst = 0;
        bus(0, 2'd0, 8'h00);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule